// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects thirty-two peripheral interrupt lines and one non-maskable line, keeps a pending flag for each, and offers the most urgent pending, enabled request to a processor core. The core sees a request-valid strobe together with an interrupt number. It takes the request with an acknowledge and, when the handler finishes, signals that with an exit strobe. The non-maskable line uses number 32. Configurable lines use their own index, 0 to 31.

Software configures the block through a word-wide register port. Enables and pending flags each have a set register and a clear register. Each line has a two-bit urgency field packed four to a word. Whether a line is level-sensitive or pulse-type is fixed at integration by a parameter mask, `LEVEL_LINES`; a 1 in bit i makes line i level-sensitive. All inputs are assumed synchronous to `clk`.

One handler is tracked as active at a time. While a handler is active, only a strictly more urgent request is offered. In the cycle that the exit strobe is high, the next request is already offered, so a handler can follow the previous one with no idle cycle between them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0x00000000, all lines are disabled and not pending, every urgency is 0, and `req_valid` is low.
- R2: Writing a 1 to a bit at offset 0x100 enables that line, writing a 1 at offset 0x180 disables it, and zero bits have no effect. Both offsets read back the enable vector, with bit i for line i. Unmapped offsets read 0 and ignore writes.
- R3: Writing a 1 at offset 0x200 sets that line's pending flag, writing a 1 at offset 0x280 clears it, and zero bits have no effect. Both offsets read back the pending vector, with bit i for line i.
- R4: Urgency words sit at offsets 0x400 + 4k. Line 4k+j uses bits 8j+7:8j+6 of word k. All other bits read 0 and ignore writes.
- R5: Among lines that are both pending and enabled, the smallest urgency value wins. On a tie, the lowest line number wins. Disabled lines are never offered.
- R6: On a pulse-type line, a rising edge sets the pending flag. The flag stays set after the input falls. An input that stays high does not set the flag again after its handler ends.
- R7: A level-sensitive line is set pending while its input is high and the line is not active. If the input is still high once the handler has ended, the line becomes pending again. If the input is low, it does not.
- R8: A rising edge on `nmi_in` creates a request with number 32. This request outranks every configurable line and ignores the enables.
- R9: An acknowledge of an offered request clears that line's pending flag and makes the line active. While a line is active, a request is offered only if its urgency is strictly smaller than the active one.
- R10: In the cycle that `req_exit` is high, the most urgent pending request is offered as if no line were active. An acknowledge in that same cycle starts the next handler directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Peripheral interrupt lines |
| nmi_in | input | 1 | Non-maskable interrupt line |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read |
| req_valid | output | 1 | A request is offered to the core |
| req_id | output | 6 | Offered interrupt number (32 = non-maskable) |
| req_ack | input | 1 | Core takes the offered request |
| req_exit | input | 1 | Core ends the active handler |

## Verification
The hardest state to reach is a handler exit while other requests wait that could not preempt the active handler. To get there, the stimulus parks requests of lower and equal urgency behind an active handler, then raises and withdraws a more urgent one. It then drives exit, and exit together with acknowledge, and samples `req_id` inside the exit cycle itself. Level lines are handed over with their inputs still high across the exit, which shows the re-pend one cycle after the active state clears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned NUM_LINES = 32;
  localparam int unsigned PRIO_W    = 2;
  localparam int unsigned LINE_W    = $clog2(NUM_LINES);
  localparam int unsigned ID_W      = LINE_W + 1;
  localparam int unsigned URG_W     = PRIO_W + 1;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned PRIO_WORDS = NUM_LINES / LANES;

  localparam logic [ID_W-1:0]   NMI_ID   = ID_W'(NUM_LINES);
  localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'h180;
  localparam logic [ADDR_W-1:0] OFS_PND_SET = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_PND_CLR = 12'h280;
  localparam logic [ADDR_W-1:0] OFS_PRIO    = 12'h400;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_wr,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic [NUM_LINES-1:0]        pend_q,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_LINES-1:0]        en_q,
  output logic [NUM_LINES*PRIO_W-1:0] prio_q,
  output logic [NUM_LINES-1:0]        sw_set,
  output logic [NUM_LINES-1:0]        sw_clr
);
  localparam int unsigned WIDX_W = $clog2(PRIO_WORDS);
  localparam int unsigned WBASE_LSB = WIDX_W + 2;

  logic                    wr_en_set, wr_en_clr, wr_pnd_set, wr_pnd_clr, wr_prio;
  logic                    hit_prio;
  logic [WIDX_W-1:0]       word_idx;
  logic [NUM_LINES-1:0]    en_d;
  logic                    en_ce;

  assign hit_prio  = (bus_addr[ADDR_W-1:WBASE_LSB] == OFS_PRIO[ADDR_W-1:WBASE_LSB])
                     && (bus_addr[1:0] == 2'b00);
  assign word_idx  = bus_addr[WBASE_LSB-1:2];
  assign wr_en_set  = bus_sel && bus_wr && (bus_addr == OFS_EN_SET);
  assign wr_en_clr  = bus_sel && bus_wr && (bus_addr == OFS_EN_CLR);
  assign wr_pnd_set = bus_sel && bus_wr && (bus_addr == OFS_PND_SET);
  assign wr_pnd_clr = bus_sel && bus_wr && (bus_addr == OFS_PND_CLR);
  assign wr_prio    = bus_sel && bus_wr && hit_prio;

  assign sw_set = wr_pnd_set ? bus_wdata[NUM_LINES-1:0] : '0;
  assign sw_clr = wr_pnd_clr ? bus_wdata[NUM_LINES-1:0] : '0;

  // enable vector: next state then register
  assign en_ce = wr_en_set || wr_en_clr;
  always_comb begin
    en_d = en_q;
    if (wr_en_set) en_d = en_q | bus_wdata[NUM_LINES-1:0];
    if (wr_en_clr) en_d = en_q & ~bus_wdata[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  // per-line urgency field, top two bits of its byte lane
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
    localparam int unsigned WORD = i / LANES;
    localparam int unsigned LSB  = 8 * (i % LANES) + (8 - PRIO_W);
    logic prio_ce;
    assign prio_ce = wr_prio && (word_idx == WIDX_W'(WORD));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prio_q[i*PRIO_W +: PRIO_W] <= '0;
      else if (prio_ce) prio_q[i*PRIO_W +: PRIO_W] <= bus_wdata[LSB +: PRIO_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if ((bus_addr == OFS_EN_SET) || (bus_addr == OFS_EN_CLR)) begin
        bus_rdata = DATA_W'(en_q);
      end else if ((bus_addr == OFS_PND_SET) || (bus_addr == OFS_PND_CLR)) begin
        bus_rdata = DATA_W'(pend_q);
      end else if (hit_prio) begin
        for (int j = 0; j < LANES; j++) begin
          bus_rdata[8*j + (8-PRIO_W) +: PRIO_W] =
            prio_q[(int'(word_idx)*LANES + j)*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
  import irqc_pkg::*;
#(
  parameter logic [NUM_LINES-1:0] LEVEL_LINES = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic [NUM_LINES-1:0] sw_set,
  input  logic [NUM_LINES-1:0] sw_clr,
  input  logic [NUM_LINES-1:0] ack_mask,
  input  logic                 ack_nmi,
  input  logic [NUM_LINES-1:0] act_mask,
  output logic [NUM_LINES-1:0] pend_q,
  output logic                 nmi_pend_q
);
  logic [NUM_LINES-1:0] irq_q;
  logic [NUM_LINES-1:0] hw_set;
  logic [NUM_LINES-1:0] pend_d;
  logic                 nmi_q;
  logic                 nmi_pend_d;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sense
    if (LEVEL_LINES[i]) begin : g_level
      assign hw_set[i] = irq_in[i] && !act_mask[i];
    end else begin : g_pulse
      assign hw_set[i] = irq_in[i] && !irq_q[i];
    end
  end

  // clear sources win over set sources in the same cycle
  assign pend_d     = (pend_q | hw_set | sw_set) & ~(sw_clr | ack_mask);
  assign nmi_pend_d = (nmi_pend_q || (nmi_in && !nmi_q)) && !ack_nmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q      <= '0;
      nmi_q      <= 1'b0;
      pend_q     <= '0;
      nmi_pend_q <= 1'b0;
    end else begin
      irq_q      <= irq_in;
      nmi_q      <= nmi_in;
      pend_q     <= pend_d;
      nmi_pend_q <= nmi_pend_d;
    end
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
(
  input  logic [NUM_LINES-1:0]        pend,
  input  logic [NUM_LINES-1:0]        en,
  input  logic [NUM_LINES*PRIO_W-1:0] prio,
  input  logic                        nmi_pend,
  output logic                        cand_valid,
  output logic [ID_W-1:0]             cand_id,
  output logic [URG_W-1:0]            cand_urg
);
  // urgency 0 is reserved for the non-maskable source
  always_comb begin
    cand_valid = nmi_pend;
    cand_id    = NMI_ID;
    cand_urg   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      logic [URG_W-1:0] urg_i;
      urg_i = {1'b0, prio[i*PRIO_W +: PRIO_W]} + URG_W'(1);
      if (pend[i] && en[i] && (!cand_valid || (urg_i < cand_urg))) begin
        cand_valid = 1'b1;
        cand_id    = ID_W'(i);
        cand_urg   = urg_i;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter logic [NUM_LINES-1:0] LEVEL_LINES = 32'hFFFF_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 nmi_in,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 req_valid,
  output logic [ID_W-1:0]      req_id,
  input  logic                 req_ack,
  input  logic                 req_exit
);
  logic                        rst_sync_n;
  logic [NUM_LINES-1:0]        en_q, pend_q, sw_set, sw_clr, ack_mask, act_mask;
  logic [NUM_LINES*PRIO_W-1:0] prio_q;
  logic                        nmi_pend_q, ack_nmi;
  logic                        cand_valid;
  logic [ID_W-1:0]             cand_id;
  logic [URG_W-1:0]            cand_urg;
  logic                        act_valid_q, act_valid_d;
  logic [ID_W-1:0]             act_id_q, act_id_d;
  logic [URG_W-1:0]            act_urg_q, act_urg_d;
  logic                        take, act_ce;

  irqc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pend_q(pend_q),
    .bus_rdata(bus_rdata), .en_q(en_q), .prio_q(prio_q),
    .sw_set(sw_set), .sw_clr(sw_clr)
  );

  irqc_pend #(.LEVEL_LINES(LEVEL_LINES)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .sw_set(sw_set), .sw_clr(sw_clr), .ack_mask(ack_mask), .ack_nmi(ack_nmi),
    .act_mask(act_mask), .pend_q(pend_q), .nmi_pend_q(nmi_pend_q)
  );

  irqc_arb u_arb (
    .pend(pend_q), .en(en_q), .prio(prio_q), .nmi_pend(nmi_pend_q),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_urg(cand_urg)
  );

  // exit releases the active level within the same cycle (tail-chain)
  assign req_valid = cand_valid && (!act_valid_q || req_exit || (cand_urg < act_urg_q));
  assign req_id    = cand_id;
  assign take      = req_valid && req_ack;

  assign ack_nmi  = take && (cand_id == NMI_ID);
  assign ack_mask = (take && (cand_id != NMI_ID))
                    ? (NUM_LINES'(1) << cand_id[LINE_W-1:0]) : '0;
  assign act_mask = (act_valid_q && (act_id_q != NMI_ID))
                    ? (NUM_LINES'(1) << act_id_q[LINE_W-1:0]) : '0;

  assign act_ce = take || req_exit;
  always_comb begin
    act_valid_d = act_valid_q;
    act_id_d    = act_id_q;
    act_urg_d   = act_urg_q;
    if (take) begin
      act_valid_d = 1'b1;
      act_id_d    = cand_id;
      act_urg_d   = cand_urg;
    end else if (req_exit) begin
      act_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      act_valid_q <= 1'b0;
      act_id_q    <= '0;
      act_urg_q   <= '0;
    end else if (act_ce) begin
      act_valid_q <= act_valid_d;
      act_id_q    <= act_id_d;
      act_urg_q   <= act_urg_d;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic [ID_W-1:0]             req_id,
  input logic                        req_ack,
  input logic                        req_exit,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [NUM_LINES-1:0]        en_q,
  input logic [NUM_LINES-1:0]        pend_q,
  input logic [NUM_LINES*PRIO_W-1:0] prio_q,
  input logic                        nmi_pend,
  input logic                        act_valid,
  input logic [ID_W-1:0]             act_id,
  input logic [URG_W-1:0]            act_urg
);
  logic [URG_W-1:0] req_urg;
  logic             req_is_line;

  assign req_is_line = (req_id != NMI_ID);
  always_comb begin
    req_urg = '0;
    if (req_is_line) req_urg = {1'b0, prio_q[req_id[LINE_W-1:0]*PRIO_W +: PRIO_W]} + URG_W'(1);
  end

  AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_line) |-> (en_q[req_id[LINE_W-1:0]] && pend_q[req_id[LINE_W-1:0]])); // R5

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && nmi_pend) |-> (req_id == NMI_ID)); // R8

  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack) |=> (act_valid && (act_id == $past(req_id)))); // R9

  AST_ACK_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ack && req_is_line && !(bus_sel && bus_wr))
    |=> !pend_q[$past(req_id[LINE_W-1:0])]); // R9

  AST_PREEMPT_STRICT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && act_valid && !req_exit) |-> (req_urg < act_urg)); // R9

  AST_EXIT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_exit && !(req_valid && req_ack)) |=> !act_valid); // R10
endmodule

bind prio_irq_ctrl irqc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_ack(req_ack), .req_exit(req_exit), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q), .nmi_pend(nmi_pend_q),
  .act_valid(act_valid_q), .act_id(act_id_q), .act_urg(act_urg_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] irq_in;
  logic        nmi_in;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        req_valid;
  logic [5:0]  req_id;
  logic        req_ack, req_exit;

  int checks = 0;
  int failures = 0;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_valid(req_valid),
    .req_id(req_id), .req_ack(req_ack), .req_exit(req_exit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {write offset, write data, read offset, expected read}
  localparam int NV = 12;
  localparam logic [87:0] VEC [NV] = '{
    {12'h100, 32'h0000_00F0, 12'h100, 32'h0000_00F0},
    {12'h100, 32'h0000_0003, 12'h180, 32'h0000_00F3},
    {12'h180, 32'h0000_0011, 12'h100, 32'h0000_00E2},
    {12'h180, 32'h0000_0000, 12'h100, 32'h0000_00E2},
    {12'h200, 32'h8000_0001, 12'h200, 32'h8000_0001},
    {12'h280, 32'h0000_0001, 12'h280, 32'h8000_0000},
    {12'h280, 32'h8000_0000, 12'h200, 32'h0000_0000},
    {12'h400, 32'hFFFF_FFFF, 12'h400, 32'hC0C0_C0C0},
    {12'h41C, 32'h4080_C000, 12'h41C, 32'h4080_C000},
    {12'h404, 32'h1234_5678, 12'h404, 32'h0000_4040},
    {12'h300, 32'hFFFF_FFFF, 12'h300, 32'h0000_0000},
    {12'h000, 32'hFFFF_FFFF, 12'h100, 32'h0000_00E2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk); req_ack = 1'b1;
    @(negedge clk); req_ack = 1'b0;
  endtask

  task automatic hexit;
    @(negedge clk); req_exit = 1'b1;
    @(negedge clk); req_exit = 1'b0;
  endtask

  // request state as {valid, id} packed for one compare
  task automatic check_req(input string req, input logic v, input logic [5:0] id);
    #1;
    if (v) check(req, {25'd0, req_valid, req_id}, {25'd0, 1'b1, id});
    else   check(req, {31'd0, req_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; irq_in = '0; nmi_in = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    req_ack = 1'b0; req_exit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    brd(12'h100, rd); check("R1 enable", rd, 32'h0);
    brd(12'h200, rd); check("R1 pending", rd, 32'h0);
    for (int k = 0; k < 8; k++) begin
      brd(12'h400 + 12'(4*k), rd); check("R1 urgency", rd, 32'h0);
    end
    check_req("R1 req", 1'b0, 6'd0);

    // R2 R3 R4 register vectors
    for (int v = 0; v < NV; v++) begin
      bwr(VEC[v][87:76], VEC[v][75:44]);
      brd(VEC[v][43:32], rd);
      check("R2/R3/R4 vector", rd, VEC[v][31:0]);
    end
    bwr(12'h180, 32'hFFFF_FFFF);
    bwr(12'h280, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) bwr(12'h400 + 12'(4*k), 32'h0);

    // R5 arbitration: line3 urg2, lines 5 and 9 urg1, line12 urg0 disabled
    bwr(12'h400, 32'h8000_0000);
    bwr(12'h404, 32'h0000_4000);
    bwr(12'h408, 32'h0000_4000);
    bwr(12'h100, 32'h0000_0228);
    bwr(12'h200, 32'h0000_1228);
    check_req("R5 tie lowest id", 1'b1, 6'd5);
    bwr(12'h280, 32'h0000_0020);
    check_req("R5 next", 1'b1, 6'd9);
    bwr(12'h280, 32'h0000_0200);
    check_req("R5 least urgent", 1'b1, 6'd3);
    bwr(12'h280, 32'h0000_0008);
    check_req("R5 disabled ignored", 1'b0, 6'd0);
    bwr(12'h100, 32'h0000_1000);
    check_req("R5 enabled now", 1'b1, 6'd12);
    bwr(12'h280, 32'hFFFF_FFFF);

    // R9 R10 ack, strict preemption and tail-chaining
    bwr(12'h200, 32'h0000_0208);
    check_req("R9 offer", 1'b1, 6'd9);
    ack();
    check_req("R9 less urgent held", 1'b0, 6'd0);
    brd(12'h200, rd); check("R9 ack clears pending", rd, 32'h0000_0008);
    bwr(12'h200, 32'h0000_0020);
    check_req("R9 equal held", 1'b0, 6'd0);
    bwr(12'h200, 32'h0000_1000);
    check_req("R9 more urgent preempts", 1'b1, 6'd12);
    bwr(12'h280, 32'h0000_1000);
    check_req("R9 withdrawn", 1'b0, 6'd0);
    @(negedge clk); req_exit = 1'b1;
    check_req("R10 exit cycle offer", 1'b1, 6'd5);
    req_ack = 1'b1;
    @(negedge clk); req_exit = 1'b0; req_ack = 1'b0;
    check_req("R10 chained active", 1'b0, 6'd0);
    brd(12'h200, rd); check("R10 chained pending", rd, 32'h0000_0008);
    @(negedge clk); req_exit = 1'b1;
    check_req("R10 exit offer", 1'b1, 6'd3);
    @(negedge clk); req_exit = 1'b0;
    check_req("R10 after exit", 1'b1, 6'd3);
    ack(); hexit();
    check_req("R10 idle", 1'b0, 6'd0);

    // R6 pulse line 2
    bwr(12'h100, 32'h0000_0004);
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk); irq_in[2] = 1'b0;
    check_req("R6 edge latched", 1'b1, 6'd2);
    ack(); hexit(); repeat (2) @(negedge clk);
    check_req("R6 no re-pend", 1'b0, 6'd0);
    @(negedge clk); irq_in[2] = 1'b1;
    @(negedge clk);
    check_req("R6 second edge", 1'b1, 6'd2);
    ack(); hexit(); repeat (3) @(negedge clk);
    check_req("R6 held high", 1'b0, 6'd0);
    irq_in[2] = 1'b0;

    // R7 level line 20
    bwr(12'h100, 32'h0010_0000);
    @(negedge clk); irq_in[20] = 1'b1;
    @(negedge clk);
    check_req("R7 level offer", 1'b1, 6'd20);
    ack(); repeat (2) @(negedge clk);
    brd(12'h200, rd); check("R7 no pend while active", rd, 32'h0);
    hexit(); @(negedge clk);
    check_req("R7 re-pend after exit", 1'b1, 6'd20);
    irq_in[20] = 1'b0;
    ack(); hexit(); repeat (2) @(negedge clk);
    check_req("R7 low stays idle", 1'b0, 6'd0);

    // R8 non-maskable
    bwr(12'h180, 32'hFFFF_FFFF);
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    check_req("R8 unmaskable", 1'b1, 6'd32);
    bwr(12'h100, 32'h0000_1000);
    bwr(12'h200, 32'h0000_1000);
    check_req("R8 outranks urgency 0", 1'b1, 6'd32);
    ack();
    check_req("R8 nothing preempts", 1'b0, 6'd0);
    @(negedge clk); req_exit = 1'b1;
    check_req("R8 R10 exit hands on", 1'b1, 6'd12);
    @(negedge clk); req_exit = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule